// File: doc/BRIEF.md
# Scaled PWM Clock Prescaler

This block produces the counting clocks for an eight-channel pulse-width modulator. It receives two prescaled clock-enable pulse trains, A and B, at the bus clock rate. From each it derives a slower scaled train, SA from A and SB from B. Each scaled path has an 8-bit down counter followed by a divide-by-two stage. The scaled rate is therefore the input rate divided by twice a programmable scale value. A scale value of zero counts as 256.

Software loads a scale value through a one-cycle write strobe for each path and a shared data bus. A write reloads that path's counter and clears its divide-by-two stage at once. The new rate therefore applies from the next input pulse and does not wait for the old count to run out.

Channels fall into two groups. Group A may use only A or SA, and group B may use only B or SB. Each channel has a two-bit selection made of a scale bit and a group bit. All outputs are single-cycle clock-enable pulses.

Top module: `pwm_clkscale_top`

## Requirements
- R1: After reset both scale values are 0 and every channel forwards its own group's unscaled clock. No scaled pulse appears before 512 input pulses of its path have been received.
- R2: Each input pulse decrements the path's counter. An input pulse that finds the counter at 1 is a terminal pulse: it reloads the scale value in the same step instead of decrementing.
- R3: Each path's divide-by-two stage toggles on every terminal pulse. The scaled output pulses on every second terminal pulse. It is high for exactly one cycle, only in a cycle where the path's input pulse is high, and the spacing is 2×S input pulses for a scale value S from 1 to 255.
- R4: A scale value of 0 acts as 256, so scaled pulses are 512 input pulses apart.
- R5: A write to a path's scale register loads the new value into its counter and clears its divide-by-two stage, whatever the old count or phase. An input pulse in the same cycle as the write is not counted. The first scaled pulse after the write comes on the 2×S-th input pulse after it.
- R6: Channel c belongs to group B when bit 1 of its index is 1 (channels 2, 3, 6, 7), otherwise to group A (0, 1, 4, 5). A channel only ever forwards pulses of its own group's clocks.
- R7: For each channel, the scale bit (sel_pri) set to 1 requests the scaled clock, and the group bit (sel_sec) names a group (0 = A, 1 = B). The scaled clock is forwarded only when the scale bit is 1 and the group bit names the channel's own group. Otherwise the channel forwards its own unscaled clock.
- R8: The two paths are independent: A pulses and A writes never move the SB spacing, and B pulses and B writes never move the SA spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_a_en | input | 1 | Prescaled clock A enable pulse |
| clk_b_en | input | 1 | Prescaled clock B enable pulse |
| scl_a_wr | input | 1 | Write strobe for scale value of path A |
| scl_b_wr | input | 1 | Write strobe for scale value of path B |
| scl_wdata | input | SCALE_W | Scale value written by either strobe |
| sel_pri | input | NUM_CH | Per-channel scale bit |
| sel_sec | input | NUM_CH | Per-channel group bit |
| ch_clk_en | output | NUM_CH | Per-channel counting clock enable |
| clk_sa_en | output | 1 | Scaled clock SA enable pulse |
| clk_sb_en | output | 1 | Scaled clock SB enable pulse |

## Verification
The bench runs A and B at different input rates, four and three bus cycles per pulse, so that a path that took the wrong input would show up as a spacing error. Spacings are measured in input pulses for the boundary scale values 0, 1 and 255 and for a set of random values, after reset and after each write. Writes land mid-count and also while the divide-by-two stage is half way through, which separates a correct reload from one that keeps the old phase. Every channel is swept through all four select codes, plus mixed patterns, and compared with the pulse trains predicted for its group.

// File: rtl/pwm_clk_pkg.sv
package pwm_clk_pkg;

  typedef enum logic {GRP_A = 1'b0, GRP_B = 1'b1} clk_group_e;

  // Group of a channel: index bit 1 picks B.
  function automatic clk_group_e ch_group(input int unsigned ch);
    return ((ch >> 1) & 1) != 0 ? GRP_B : GRP_A;
  endfunction

  // Input pulses between two scaled pulses; zero means full scale.
  function automatic int unsigned scaled_span(input int unsigned scale,
                                              input int unsigned width);
    int unsigned eff;
    eff = (scale == 0) ? (1 << width) : scale;
    return 2 * eff;
  endfunction

endpackage

// File: rtl/pwm_scale_div.sv
module pwm_scale_div #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic         scaled_o,
  output logic         hit_o,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] scale_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] scale_q;
  logic [W-1:0] cnt_q;
  logic         half_q;

  // terminal pulse: input pulse meeting a count of one, no write pending
  assign hit_o    = tick_i && !wr_i && (cnt_q == ONE);
  assign scaled_o = hit_o && half_q;
  assign cnt_o    = cnt_q;
  assign scale_o  = scale_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scale_q <= '0;
      cnt_q   <= '0;
      half_q  <= 1'b0;
    end else if (wr_i) begin
      scale_q <= wdata_i;
      cnt_q   <= wdata_i;
      half_q  <= 1'b0;
    end else if (hit_o) begin
      cnt_q   <= scale_q;
      half_q  <= ~half_q;
    end else if (tick_i) begin
      cnt_q   <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/pwm_ch_mux.sv
module pwm_ch_mux
  import pwm_clk_pkg::*;
#(
  parameter clk_group_e GROUP = GRP_A
) (
  input  logic pri_i,
  input  logic sec_i,
  input  logic a_i,
  input  logic sa_i,
  input  logic b_i,
  input  logic sb_i,
  output logic en_o
);
  logic own_raw;
  logic own_scaled;
  logic take_scaled;

  always_comb begin
    own_raw     = (GROUP == GRP_B) ? b_i  : a_i;
    own_scaled  = (GROUP == GRP_B) ? sb_i : sa_i;
    take_scaled = pri_i && (sec_i == logic'(GROUP));
    en_o        = take_scaled ? own_scaled : own_raw;
  end
endmodule

// File: rtl/pwm_clkscale_top.sv
module pwm_clkscale_top
  import pwm_clk_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned SCALE_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clk_a_en,
  input  logic               clk_b_en,
  input  logic               scl_a_wr,
  input  logic               scl_b_wr,
  input  logic [SCALE_W-1:0] scl_wdata,
  input  logic [NUM_CH-1:0]  sel_pri,
  input  logic [NUM_CH-1:0]  sel_sec,
  output logic [NUM_CH-1:0]  ch_clk_en,
  output logic               clk_sa_en,
  output logic               clk_sb_en
);
  localparam int unsigned NPATH = 2;

  logic               tick   [NPATH];
  logic               wr     [NPATH];
  logic               scaled [NPATH];
  logic               hit    [NPATH];
  logic [SCALE_W-1:0] cnt    [NPATH];
  logic [SCALE_W-1:0] scale  [NPATH];

  assign tick[0] = clk_a_en;
  assign tick[1] = clk_b_en;
  assign wr[0]   = scl_a_wr;
  assign wr[1]   = scl_b_wr;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    pwm_scale_div #(.W(SCALE_W)) div_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick[p]),
      .wr_i     (wr[p]),
      .wdata_i  (scl_wdata),
      .scaled_o (scaled[p]),
      .hit_o    (hit[p]),
      .cnt_o    (cnt[p]),
      .scale_o  (scale[p])
    );
  end

  assign clk_sa_en = scaled[0];
  assign clk_sb_en = scaled[1];

  // internal events named for the checker
  logic               a_hit, b_hit;
  logic [SCALE_W-1:0] a_cnt, b_cnt, a_scale, b_scale;
  assign a_hit   = hit[0];
  assign b_hit   = hit[1];
  assign a_cnt   = cnt[0];
  assign b_cnt   = cnt[1];
  assign a_scale = scale[0];
  assign b_scale = scale[1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_ch_mux #(.GROUP(ch_group(c))) mux_i (
      .pri_i (sel_pri[c]),
      .sec_i (sel_sec[c]),
      .a_i   (clk_a_en),
      .sa_i  (scaled[0]),
      .b_i   (clk_b_en),
      .sb_i  (scaled[1]),
      .en_o  (ch_clk_en[c])
    );
  end
endmodule

// File: rtl/pwm_clkscale_chk.sv
module pwm_clkscale_chk
  import pwm_clk_pkg::*;
#(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned SCALE_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               clk_a_en,
  input logic               clk_b_en,
  input logic               scl_a_wr,
  input logic               scl_b_wr,
  input logic [SCALE_W-1:0] scl_wdata,
  input logic [NUM_CH-1:0]  sel_pri,
  input logic [NUM_CH-1:0]  ch_clk_en,
  input logic               clk_sa_en,
  input logic               clk_sb_en,
  input logic               a_hit,
  input logic               b_hit,
  input logic [SCALE_W-1:0] a_cnt,
  input logic [SCALE_W-1:0] b_cnt,
  input logic [SCALE_W-1:0] a_scale,
  input logic [SCALE_W-1:0] b_scale
);
  localparam logic [SCALE_W-1:0] ONE = SCALE_W'(1);

  assert_sa_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sa_en |-> clk_a_en);
  assert_sb_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clk_sb_en |-> clk_b_en);

  assert_a_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    a_hit |=> (a_cnt == $past(a_scale)));
  assert_b_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    b_hit |=> (b_cnt == $past(b_scale)));

  assert_a_decrement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_a_en && !scl_a_wr && a_cnt != ONE) |=> (a_cnt == $past(a_cnt) - ONE));

  assert_a_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_a_wr |=> ((a_cnt == $past(scl_wdata)) && !clk_sa_en));
  assert_b_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    scl_b_wr |=> ((b_cnt == $past(scl_wdata)) && !clk_sb_en));

  assert_a_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_a_en && !scl_a_wr) |=> $stable(a_cnt));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    localparam bit IS_B = (ch_group(c) == GRP_B);
    assert_group_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ch_clk_en[c] |-> (IS_B ? clk_b_en : clk_a_en));
    assert_raw_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_pri[c] |-> (ch_clk_en[c] == (IS_B ? clk_b_en : clk_a_en)));
  end
endmodule

bind pwm_clkscale_top pwm_clkscale_chk #(.NUM_CH(NUM_CH), .SCALE_W(SCALE_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .clk_a_en  (clk_a_en),
  .clk_b_en  (clk_b_en),
  .scl_a_wr  (scl_a_wr),
  .scl_b_wr  (scl_b_wr),
  .scl_wdata (scl_wdata),
  .sel_pri   (sel_pri),
  .ch_clk_en (ch_clk_en),
  .clk_sa_en (clk_sa_en),
  .clk_sb_en (clk_sb_en),
  .a_hit     (a_hit),
  .b_hit     (b_hit),
  .a_cnt     (a_cnt),
  .b_cnt     (b_cnt),
  .a_scale   (a_scale),
  .b_scale   (b_scale)
);

// File: tb/pwm_clkscale_top_tb_top.sv
module pwm_clkscale_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH   = 8;
  localparam int W     = 8;
  localparam int A_DIV = 4;
  localparam int B_DIV = 3;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           clk_a_en, clk_b_en, scl_a_wr, scl_b_wr;
  logic [W-1:0]   scl_wdata;
  logic [NCH-1:0] sel_pri, sel_sec, ch_clk_en;
  logic           clk_sa_en, clk_sb_en;

  int total = 0;
  int bad   = 0;
  int pa = 0, pb = 0;
  int ta = 0, tb = 0;          // input pulses since last reference point
  int gap_a = 0, gap_b = 0;
  bit seen_a = 0, seen_b = 0;
  int ch_err = 0, tick_err = 0, width_err = 0;
  bit prev_sa = 0, prev_sb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_clkscale_top #(.NUM_CH(NCH), .SCALE_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_a_en(clk_a_en), .clk_b_en(clk_b_en),
    .scl_a_wr(scl_a_wr), .scl_b_wr(scl_b_wr), .scl_wdata(scl_wdata),
    .sel_pri(sel_pri), .sel_sec(sel_sec), .ch_clk_en(ch_clk_en),
    .clk_sa_en(clk_sa_en), .clk_sb_en(clk_sb_en)
  );

  function automatic int span(input int s);
    return (s == 0) ? 512 : 2 * s;
  endfunction

  function automatic bit expect_ch(input int c, input bit a, input bit sa,
                                   input bit b, input bit sb);
    bit grp_b;
    grp_b = ((c / 2) % 2) == 1;
    if (grp_b) return (sel_pri[c] && sel_sec[c]) ? sb : b;
    return (sel_pri[c] && !sel_sec[c]) ? sa : a;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one bus cycle: drive after the falling edge, sample 1 time unit later
  task automatic step(input bit wa, input bit wb, input int d);
    @(negedge clk);
    clk_a_en  = (pa == 0);
    clk_b_en  = (pb == 0);
    pa        = (pa + 1) % A_DIV;
    pb        = (pb + 1) % B_DIV;
    scl_a_wr  = wa;
    scl_b_wr  = wb;
    scl_wdata = W'(d);
    #1;
    if (scl_a_wr) ta = 0; else if (clk_a_en) ta++;
    if (scl_b_wr) tb = 0; else if (clk_b_en) tb++;
    if (clk_sa_en) begin gap_a = ta; ta = 0; seen_a = 1; end
    if (clk_sb_en) begin gap_b = tb; tb = 0; seen_b = 1; end
    if (clk_sa_en && !clk_a_en) tick_err++;
    if (clk_sb_en && !clk_b_en) tick_err++;
    if ((clk_sa_en && prev_sa) || (clk_sb_en && prev_sb)) width_err++;
    prev_sa = clk_sa_en;
    prev_sb = clk_sb_en;
    for (int c = 0; c < NCH; c++)
      if (ch_clk_en[c] !== expect_ch(c, clk_a_en, clk_sa_en, clk_b_en, clk_sb_en))
        ch_err++;
  endtask

  task automatic wait_sa(input string req, input int exp);
    int n = 0;
    seen_a = 0;
    while (!seen_a && n < 6000) begin step(0, 0, 0); n++; end
    chk(seen_a && gap_a == exp, req, seen_a ? gap_a : -1, exp);
  endtask

  task automatic wait_sb(input string req, input int exp);
    int n = 0;
    seen_b = 0;
    while (!seen_b && n < 6000) begin step(0, 0, 0); n++; end
    chk(seen_b && gap_b == exp, req, seen_b ? gap_b : -1, exp);
  endtask

  task automatic run_a(input int s, input int pulses, input string req);
    step(1, 0, s);
    for (int k = 0; k < pulses; k++) wait_sa(req, span(s));
  endtask

  task automatic run_b(input int s, input int pulses, input string req);
    step(0, 1, s);
    for (int k = 0; k < pulses; k++) wait_sb(req, span(s));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    chk(0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 0; clk_a_en = 0; clk_b_en = 0; scl_a_wr = 0; scl_b_wr = 0;
    scl_wdata = '0; sel_pri = '0; sel_sec = '0;
    repeat (3) @(negedge clk);
    #1;
    rst_n = 1;
    ta = 0; tb = 0;

    // R1: no scaled pulse before 512 pulses; selection at reset is raw clock
    ch_err = 0;
    wait_sa("R1 first SA after reset", 512);
    chk(ch_err == 0, "R1 reset routing", ch_err, 0);

    // R2/R3/R4 boundary scale values on A
    run_a(0,   2, "R4 SA scale 0");
    run_a(1,   3, "R3 SA scale 1");
    run_a(255, 2, "R2 SA scale 255");
    // R2/R3/R4 boundary scale values on B
    run_b(0,   2, "R4 SB scale 0");
    run_b(1,   3, "R3 SB scale 1");
    run_b(255, 2, "R2 SB scale 255");

    // random values on both paths
    for (int i = 0; i < 6; i++) begin
      int s = $urandom_range(2, 254);
      run_a(s, 2, "R3 SA random");
      s = $urandom_range(2, 254);
      run_b(s, 2, "R3 SB random");
    end

    // R5: mid-count write restarts the count
    step(1, 0, 20);
    while (ta < 7) step(0, 0, 0);
    step(1, 0, 3);
    wait_sa("R5 mid-count rewrite", 6);
    // R5: write when divider is half way clears the phase
    step(1, 0, 5);
    while (ta < 5) step(0, 0, 0);
    step(1, 0, 4);
    wait_sa("R5 divider cleared", 8);

    // R8: B spacing untouched by A writes in between
    step(0, 1, 6);
    wait_sb("R8 SB before A writes", 12);
    step(1, 0, 9);
    step(1, 0, 2);
    wait_sb("R8 SB with A writes", 12);
    wait_sa("R8 SA with B running", 4);

    chk(tick_err == 0, "R3 scaled pulse on input pulse", tick_err, 0);
    chk(width_err == 0, "R3 single-cycle scaled pulse", width_err, 0);

    // R6/R7: channel selection sweep with fast scaled clocks
    step(1, 1, 2);
    for (int code = 0; code < 8; code++) begin
      if (code < 4) begin
        sel_pri = {NCH{code[0]}};
        sel_sec = {NCH{code[1]}};
      end else begin
        sel_pri = NCH'($urandom);
        sel_sec = NCH'($urandom);
      end
      ch_err = 0;
      repeat (200) step(0, 0, 0);
      chk(ch_err == 0, code < 4 ? "R7 select code" : "R6 mixed group select",
          ch_err, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule